// File: doc/BRIEF.md
# Layer-Relative Header Field Extractor

This block assembles a lookup key from the header of a received packet. The header arrives as a byte stream, one byte per accepted beat. The first beat carries a start marker and the last beat carries an end marker. The start beat also presents the length of the link-layer header and the length of the network-layer header. Nine extraction slots each pick one 16-bit field. The field's position is given relative to a parsed layer boundary: the end of the link-layer header or the end of the network-layer header. Positions are not measured from the start of the frame.

Each slot is set up by one configuration byte. Two bits of that byte choose the boundary and six bits give a distance from it in 16-bit words. A slot whose byte is zero, or whose boundary code is not one of the two defined codes, takes no part in extraction. A slot can also miss its field because the header is too short. In both cases the slot reports invalid and its field reads as zero. One cycle after the end beat, all nine fields and the valid vector are presented together with a single-cycle done pulse. They then hold until the next start beat.

A small sequencer holds the state. It has three states:
- `S_IDLE`: waiting for a header.
- `S_CAPT`: counting header bytes.
- `S_DONE`: the done cycle.

The sequencer takes these transitions:
- idle→capture, on a start beat without an end marker.
- idle→done, on a start beat that is also the end beat.
- capture→capture, on an ordinary beat or on a restarting start beat.
- capture→done, on an end beat.
- done→capture, on a start beat.
- done→done, on a one-byte header.
- done→idle, otherwise.

Top module: `hfx_extract`

## Requirements
- R1: Configuration byte bits [7:6] select the boundary and bits [5:0] give a word offset. Code 01 selects the end of the link-layer header, at byte index `l2_len`. Code 10 selects the end of the network-layer header, at byte index `l2_len + l3_len`. The field starts at byte index boundary + 2 × offset, where the start beat is index 0.
- R2: A slot captures the byte at its start index into bits [15:8] of its field and the following byte into bits [7:0]. Slot i occupies `field_data[16*i+15:16*i]` and `field_vld[i]`.
- R3: Both lengths are sampled only on the start beat. Cycles with `hdr_valid` low are not counted as bytes.
- R4: A slot whose configuration byte is zero, or whose boundary code is 00 or 11, has its valid bit low and its field zero.
- R5: If the end beat arrives before a slot's second byte, that slot's valid bit is low and its field reads zero.
- R6: `done` is high for exactly the one cycle after the accepted end beat, and the results are final in that cycle.
- R7: Outputs hold their values until the next start beat. Valid beats without a start marker outside a header are ignored and raise no `done`.
- R8: A start beat that arrives while a header is being captured restarts extraction. Bytes of the abandoned header leave no trace.
- R9: A start beat may arrive in the `done` cycle. `done` still shows the finished header's results, and the new header is captured in full.
- R10: After reset, `done` is low and all fields and valid bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_start | input | 1 | Marks the first byte of a header (qualified by hdr_valid) |
| hdr_valid | input | 1 | Byte beat valid |
| hdr_end | input | 1 | Marks the last byte of a header (qualified by hdr_valid) |
| hdr_data | input | 8 | Header byte |
| l2_len | input | LEN_W | Link-layer header length in bytes, sampled on the start beat |
| l3_len | input | LEN_W | Network-layer header length in bytes, sampled on the start beat |
| slot_cfg | input | SLOTS*CFG_W | One configuration byte per slot, slot i at bits [8i+7:8i] |
| field_data | output | SLOTS*16 | Extracted fields, slot i at bits [16i+15:16i] |
| field_vld | output | SLOTS | Per-slot field valid |
| done | output | 1 | One-cycle pulse when results are final |

## Verification
The done pulse of a finished header and the start beat of the next header can fall in the same cycle. In that cycle the output registers are being cleared for the new header while `done` still advertises the old results. The bench provokes this by driving the first byte of a second header, with its start marker, in the very cycle that `done` is expected. It samples the outputs in that cycle and compares them with the first header's expected fields. It then checks that the second header's fields come out complete, which would fail if the start byte were dropped during the done state.

// File: rtl/hfx_pkg.sv
package hfx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CAPT = 2'd1,
        S_DONE = 2'd2
    } hfx_state_e;

    localparam logic [1:0] BASE_L2 = 2'b01;
    localparam logic [1:0] BASE_L3 = 2'b10;

    localparam int unsigned FLD_W  = 16;
    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/hfx_seq.sv
module hfx_seq
    import hfx_pkg::*;
#(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_start,
    input  logic             hdr_valid,
    input  logic             hdr_end,
    input  logic [LEN_W-1:0] l2_len,
    input  logic [LEN_W-1:0] l3_len,
    output logic             beat_ok,
    output logic             beat_clr,
    output logic [POS_W-1:0] beat_idx,
    output logic [LEN_W-1:0] l2_cur,
    output logic [LEN_W-1:0] l3_cur,
    output logic             done
);

    localparam logic [POS_W-1:0] IDX_MAX = '1;

    hfx_state_e       state_q, state_d;
    logic [POS_W-1:0] idx_q;
    logic [LEN_W-1:0] l2_q, l3_q;

    // beat qualification
    assign beat_clr = hdr_valid & hdr_start;
    assign beat_ok  = hdr_valid & (hdr_start | (state_q == S_CAPT));
    assign beat_idx = hdr_start ? '0 : idx_q;
    assign l2_cur   = beat_clr ? l2_len : l2_q;
    assign l3_cur   = beat_clr ? l3_len : l3_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (beat_clr) begin
                    state_d = hdr_end ? S_DONE : S_CAPT;
                end else begin
                    state_d = S_IDLE;
                end
            end
            S_CAPT: begin
                if (beat_ok && hdr_end) begin
                    state_d = S_DONE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done = (state_q == S_DONE);
    end

    // byte counter and sampled lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            l2_q  <= '0;
            l3_q  <= '0;
        end else begin
            if (beat_ok) begin
                idx_q <= (beat_idx == IDX_MAX) ? IDX_MAX : beat_idx + POS_W'(1);
            end
            if (beat_clr) begin
                l2_q <= l2_len;
                l3_q <= l3_len;
            end
        end
    end

endmodule

// File: rtl/hfx_slot.sv
module hfx_slot
    import hfx_pkg::*;
#(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned CFG_W = 8,
    parameter int unsigned POS_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [LEN_W-1:0]  l2_cur,
    input  logic [LEN_W-1:0]  l3_cur,
    input  logic              beat_ok,
    input  logic              beat_clr,
    input  logic [POS_W-1:0]  beat_idx,
    input  logic [BYTE_W-1:0] beat_data,
    output logic [FLD_W-1:0]  fld,
    output logic              fvld
);

    localparam int unsigned OFF_W = CFG_W - 2;

    logic [1:0]        code;
    logic [OFF_W-1:0]  off;
    logic              en;
    logic [POS_W-1:0]  base_w, pos_w, pos_nx;
    logic              hi_hit, lo_hit;
    logic              got_hi, got_lo;
    logic [BYTE_W-1:0] hi_q, lo_q;

    // position arithmetic
    always_comb begin
        code   = cfg[CFG_W-1 -: 2];
        off    = cfg[OFF_W-1:0];
        en     = (code == BASE_L2) || (code == BASE_L3);
        base_w = (code == BASE_L3) ? (POS_W'(l2_cur) + POS_W'(l3_cur)) : POS_W'(l2_cur);
        pos_w  = base_w + (POS_W'(off) << 1);
        pos_nx = pos_w + POS_W'(1);
        hi_hit = beat_ok & en & (beat_idx == pos_w);
        lo_hit = beat_ok & en & (beat_idx == pos_nx) & got_hi & ~beat_clr;
    end

    // capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_hi <= 1'b0;
            got_lo <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (beat_clr) begin
                got_hi <= 1'b0;
                got_lo <= 1'b0;
                hi_q   <= '0;
                lo_q   <= '0;
            end
            if (hi_hit) begin
                got_hi <= 1'b1;
                hi_q   <= beat_data;
            end
            if (lo_hit) begin
                got_lo <= 1'b1;
                lo_q   <= beat_data;
            end
        end
    end

    assign fvld = got_hi & got_lo;
    assign fld  = fvld ? {hi_q, lo_q} : '0;

endmodule

// File: rtl/hfx_extract.sv
module hfx_extract
    import hfx_pkg::*;
#(
    parameter int unsigned SLOTS = 9,
    parameter int unsigned LEN_W = 8,
    parameter int unsigned CFG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hdr_start,
    input  logic                     hdr_valid,
    input  logic                     hdr_end,
    input  logic [7:0]               hdr_data,
    input  logic [LEN_W-1:0]         l2_len,
    input  logic [LEN_W-1:0]         l3_len,
    input  logic [SLOTS*CFG_W-1:0]   slot_cfg,
    output logic [SLOTS*16-1:0]      field_data,
    output logic [SLOTS-1:0]         field_vld,
    output logic                     done
);

    localparam int unsigned POS_W = LEN_W + 2;

    logic             beat_ok, beat_clr;
    logic [POS_W-1:0] beat_idx;
    logic [LEN_W-1:0] l2_cur, l3_cur;

    hfx_seq #(
        .LEN_W(LEN_W),
        .POS_W(POS_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_start(hdr_start),
        .hdr_valid(hdr_valid),
        .hdr_end  (hdr_end),
        .l2_len   (l2_len),
        .l3_len   (l3_len),
        .beat_ok  (beat_ok),
        .beat_clr (beat_clr),
        .beat_idx (beat_idx),
        .l2_cur   (l2_cur),
        .l3_cur   (l3_cur),
        .done     (done)
    );

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        hfx_slot #(
            .LEN_W(LEN_W),
            .CFG_W(CFG_W),
            .POS_W(POS_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (slot_cfg[gi*CFG_W +: CFG_W]),
            .l2_cur   (l2_cur),
            .l3_cur   (l3_cur),
            .beat_ok  (beat_ok),
            .beat_clr (beat_clr),
            .beat_idx (beat_idx),
            .beat_data(hdr_data),
            .fld      (field_data[gi*FLD_W +: FLD_W]),
            .fvld     (field_vld[gi])
        );
    end

endmodule

// File: rtl/hfx_extract_chk.sv
module hfx_extract_chk #(
    parameter int unsigned SLOTS = 9,
    parameter int unsigned CFG_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hdr_start,
    input logic                   hdr_valid,
    input logic                   hdr_end,
    input logic [SLOTS*CFG_W-1:0] slot_cfg,
    input logic [SLOTS*16-1:0]    field_data,
    input logic [SLOTS-1:0]       field_vld,
    input logic                   done
);

    logic                  in_hdr, end_q, end_acc;
    logic [SLOTS*16-1:0]   vmask;
    logic [SLOTS-1:0]      en_mask;

    assign end_acc = hdr_valid & hdr_end & (hdr_start | in_hdr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_hdr <= 1'b0;
            end_q  <= 1'b0;
        end else begin
            end_q <= end_acc;
            if (hdr_valid && hdr_start) begin
                in_hdr <= !hdr_end;
            end else if (end_acc) begin
                in_hdr <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            vmask[i*16 +: 16] = {16{field_vld[i]}};
            en_mask[i] = slot_cfg[i*CFG_W + CFG_W - 1] ^ slot_cfg[i*CFG_W + CFG_W - 2];
        end
    end

    a_r6_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> end_q);

    a_r6_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |-> done);

    a_r7_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hdr && !(hdr_valid && hdr_start)) |=> ($stable(field_data) && $stable(field_vld)));

    a_r5_zero_if_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        ((field_data & ~vmask) == '0));

    a_r4_unused_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((field_vld & ~en_mask) == '0));

endmodule

bind hfx_extract hfx_extract_chk #(
    .SLOTS(SLOTS),
    .CFG_W(CFG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_start (hdr_start),
    .hdr_valid (hdr_valid),
    .hdr_end   (hdr_end),
    .slot_cfg  (slot_cfg),
    .field_data(field_data),
    .field_vld (field_vld),
    .done      (done)
);

// File: tb/hfx_extract_tb.sv
`timescale 1ns/1ps
module hfx_extract_tb_top;

    localparam int SLOTS = 9;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 hdr_start = 1'b0, hdr_valid = 1'b0, hdr_end = 1'b0;
    logic [7:0]           hdr_data = '0;
    logic [7:0]           l2_len = '0, l3_len = '0;
    logic [SLOTS*8-1:0]   slot_cfg = '0;
    logic [SLOTS*16-1:0]  field_data;
    logic [SLOTS-1:0]     field_vld;
    logic                 done;

    int checks = 0;
    int errors = 0;

    logic [7:0] pkt [0:255];
    int         plen, cur_l2, cur_l3;

    always #4 clk = ~clk;

    hfx_extract dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_start(hdr_start), .hdr_valid(hdr_valid),
        .hdr_end(hdr_end), .hdr_data(hdr_data), .l2_len(l2_len), .l3_len(l3_len),
        .slot_cfg(slot_cfg), .field_data(field_data), .field_vld(field_vld), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int pos_of(input logic [7:0] c);
        int off = int'(c[5:0]);
        if (c[7:6] == 2'b01) return cur_l2 + 2*off;
        if (c[7:6] == 2'b10) return cur_l2 + cur_l3 + 2*off;
        return -1;
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < SLOTS; i++) begin
            int p = pos_of(slot_cfg[i*8 +: 8]);
            logic v = (p >= 0) && (p + 1 < plen);
            logic [15:0] d = v ? {pkt[p], pkt[p+1]} : 16'h0;
            chk(req, {31'b0, field_vld[i]}, {31'b0, v});
            chk(req, {16'b0, field_data[i*16 +: 16]}, {16'b0, d});
        end
    endtask

    task automatic fill(input int n, input int seed);
        plen = n;
        for (int i = 0; i < 256; i++) pkt[i] = 8'((i*7 + seed*13 + 1) & 255);
    endtask

    task automatic set_cfg(input logic [7:0] c0, c1, c2, c3, c4, c5, c6, c7, c8);
        slot_cfg = {c8, c7, c6, c5, c4, c3, c2, c1, c0};
    endtask

    // drive n bytes; R3: lengths change to junk after the start beat
    task automatic send(input int n, input bit gaps, input bit skip_wait, input bit with_end);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                hdr_valid = 1'b0; hdr_start = 1'b0; hdr_end = 1'b0; hdr_data = 8'hEE;
            end
            if (!(skip_wait && i == 0)) @(negedge clk);
            hdr_valid = 1'b1;
            hdr_data  = pkt[i];
            hdr_start = (i == 0);
            hdr_end   = with_end && (i == n - 1);
            l2_len    = (i == 0) ? 8'(cur_l2) : 8'd3;
            l3_len    = (i == 0) ? 8'(cur_l3) : 8'd5;
        end
    endtask

    task automatic idle_inputs;
        hdr_valid = 1'b0; hdr_start = 1'b0; hdr_end = 1'b0;
    endtask

    task automatic finish_pkt(input string req);
        @(negedge clk);
        chk("R6 done pulse", {31'b0, done}, 32'd1);
        check_all(req);
        idle_inputs();
        @(negedge clk);
        chk("R6 single cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R10 done", {31'b0, done}, 32'd0);
        chk("R10 vld", {23'b0, field_vld}, 32'd0);
        chk("R10 data", {31'b0, |field_data}, 32'd0);
    endtask

    task automatic t_tcp4;
        set_cfg(8'h46, 8'h47, 8'h48, 8'h49, 8'h80, 8'h81, 8'h00, 8'h00, 8'h00);
        cur_l2 = 14; cur_l3 = 20; fill(60, 1);
        send(60, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R1 six low valid bits", {23'b0, field_vld}, 32'h3F);
        chk("R2 IPv4 src upper", {16'b0, field_data[15:0]}, {16'b0, pkt[26], pkt[27]});
        chk("R3 L4 dst port", {16'b0, field_data[5*16 +: 16]}, {16'b0, pkt[36], pkt[37]});
        check_all("R1 R2 R3 layout");
        idle_inputs();
        @(negedge clk);
        chk("R6 single cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic t_trunc;
        set_cfg(8'h46, 8'h47, 8'h48, 8'h49, 8'h80, 8'h81, 8'h00, 8'h00, 8'h00);
        cur_l2 = 14; cur_l3 = 20; fill(37, 2);
        send(37, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5 truncated slot invalid", {23'b0, field_vld}, 32'h1F);
        chk("R5 truncated slot zero", {16'b0, field_data[5*16 +: 16]}, 32'd0);
        check_all("R5");
        idle_inputs();
        @(negedge clk);
    endtask

    task automatic t_unused;
        set_cfg(8'h00, 8'hC3, 8'h05, 8'h41, 8'h82, 8'h00, 8'h3F, 8'hFF, 8'h40);
        cur_l2 = 6; cur_l3 = 10; fill(40, 3);
        send(40, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4 unused slots", {23'b0, field_vld}, 32'h118);
        check_all("R4");
        idle_inputs();
        @(negedge clk);
    endtask

    task automatic t_idle_noise;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R7 no done", {31'b0, done}, 32'd0);
            hdr_valid = 1'b1; hdr_start = 1'b0; hdr_end = (k % 2 == 0);
            hdr_data = 8'(k * 29 + 3);
        end
        @(negedge clk);
        chk("R7 no done", {31'b0, done}, 32'd0);
        idle_inputs();
        check_all("R7 held");
    endtask

    task automatic t_restart;
        set_cfg(8'h46, 8'h47, 8'h48, 8'h49, 8'h80, 8'h81, 8'h00, 8'h00, 8'h00);
        cur_l2 = 14; cur_l3 = 20; fill(60, 4);
        send(30, 1'b0, 1'b0, 1'b0);
        cur_l2 = 4; cur_l3 = 8; fill(30, 5);
        send(30, 1'b0, 1'b0, 1'b1);
        finish_pkt("R8 restart");
    endtask

    task automatic t_back2back;
        set_cfg(8'h46, 8'h47, 8'h48, 8'h49, 8'h80, 8'h81, 8'h00, 8'h00, 8'h00);
        cur_l2 = 14; cur_l3 = 20; fill(40, 6);
        send(40, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9 done with next start", {31'b0, done}, 32'd1);
        check_all("R9 first header");
        cur_l2 = 2; cur_l3 = 6; fill(24, 7);
        send(24, 1'b1, 1'b1, 1'b1);
        finish_pkt("R9 second header");
    endtask

    task automatic t_single;
        set_cfg(8'h40, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80);
        cur_l2 = 0; cur_l3 = 0; fill(1, 8);
        send(1, 1'b0, 1'b0, 1'b1);
        finish_pkt("R6 one-byte header");
        chk("R5 one byte gives no field", {23'b0, field_vld}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tcp4();
        t_idle_noise();
        t_trunc();
        t_unused();
        t_restart();
        t_back2back();
        t_single();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule